// File: doc/BRIEF.md
# Configuration ROM Header Checker

This block watches a device configuration image arrive one byte per accepted cycle, starting at offset zero. It keeps the fixed 22-byte header in registers and works out the total image size from a 10-bit length field. Two independent checksums are run while the bytes go by: an 8-bit CRC over the unique identifier and a 32-bit CRC over the data region that begins at byte 13.

When the image is complete, a single-cycle `done_o` pulse marks a verdict: pass, or a fail reason code. A revision-warning flag and the decoded header fields come with it. If the length field already shows that the image is shorter than a header, the verdict comes as soon as that field has been read. After a verdict, further bytes are ignored until `start_i` re-arms the block for the next image.

Top module: `cfgrom_hdr_checker`

## Requirements
- R1: After reset, `done_o`, `pass_o` and `rev_warn_o` are 0 and `reason_o` is 0, and the block is armed for an image starting at byte 0.
- R2: A byte is taken on every cycle with `in_valid_i` high and `start_i` low, and idle cycles between bytes are allowed. `start_i` discards any partial image, drops the byte offered in the same cycle, clears the verdict outputs and restarts at byte 0.
- R3: The image size is the low 10 bits of the little-endian word at bytes 14 (low) and 15 (high), plus 13. The upper 6 bits of byte 15 are ignored. `size_o` shows this size once byte 15 has been taken.
- R4: If the size is below 22, the verdict is given in the cycle after byte 15 is taken, with `reason_o` = 1. Reason codes: 0 none, 1 too small, 2 ID checksum, 3 data checksum.
- R5: The ID checksum runs over bytes 1 to 8. It is a CRC-8 with polynomial 0x07, initial value 0xFF, MSB-first processing and no final inversion, and it must equal byte 0. A mismatch gives `reason_o` = 2, even when the data checksum is also wrong.
- R6: The data checksum is CRC-32C (reflected polynomial 0x82F63B78, initial value all ones, final inversion) over bytes 13 to size-1. It must equal the little-endian word at bytes 9 to 12. A mismatch with a good ID checksum gives `reason_o` = 3.
- R7: `pass_o` is 1 exactly when the verdict reason is 0. `pass_o`, `reason_o` and `rev_warn_o` hold their values until `start_i`.
- R8: `rev_warn_o` is set at the verdict when byte 13 is greater than 1. It has no effect on `pass_o` or `reason_o`.
- R9: The field outputs are: `uid_o` = bytes 1 to 8 little-endian, `vendor_o` = bytes 16 and 17 LE, `model_o` = bytes 18 and 19 LE, `model_rev_o` = byte 20, `mem_rev_o` = byte 21.
- R10: After a verdict and until `start_i`, incoming bytes cause no `done_o` pulse and change no output.
- R11: `done_o` is high for exactly one cycle per image. For images of size 22 or more, that cycle follows the cycle in which byte size-1 is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Re-arm for a new image |
| in_valid_i | input | 1 | Byte strobe |
| in_data_i | input | 8 | Image byte |
| done_o | output | 1 | Verdict pulse |
| pass_o | output | 1 | Image accepted |
| reason_o | output | 2 | Fail reason code |
| rev_warn_o | output | 1 | Revision above 1 |
| size_o | output | SIZE_W | Total image size in bytes |
| uid_o | output | 64 | Unique identifier |
| vendor_o | output | 16 | Vendor identifier |
| model_o | output | 16 | Model identifier |
| model_rev_o | output | 8 | Model revision |
| mem_rev_o | output | 8 | Memory revision |

## Verification
The bench sends images of several shapes. These are the smallest legal image, a medium image with idle gaps and a high revision byte, a maximum-length image and a too-short image. Each has junk in the unused upper bits of the length byte, so that a wrong length mask or a wrong end position moves the verdict cycle. Separate images corrupt only the data checksum, or both checksums, which tells the two CRCs and their priority apart. A stream sent after a verdict shows that later bytes are ignored, and an aborted stream followed by `start_i` shows that the restart is clean. The CRC-32C model in the bench is written in the non-reflected form and is first checked against the well-known "123456789" value.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  typedef enum logic [1:0] {
    RSN_NONE     = 2'd0,
    RSN_SHORT    = 2'd1,
    RSN_ID_CRC   = 2'd2,
    RSN_DATA_CRC = 2'd3
  } reason_e;

  // CRC-8 poly 0x07, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] v;
    v = c ^ b;
    for (int i = 0; i < 8; i++) v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
    return v;
  endfunction

  // CRC-32C, reflected form
  function automatic logic [31:0] crc32c_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] v;
    v = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) v = v[0] ? ((v >> 1) ^ 32'h82F6_3B78) : (v >> 1);
    return v;
  endfunction

endpackage

// File: rtl/cfgrom_crc.sv
module cfgrom_crc import cfgrom_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [7:0]   byte_i,
  output logic [W-1:0] crc_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] crc_q;

  if (W == 32) begin : g_c32
    assign nxt_o = crc32c_step(crc_q, byte_i);
  end else begin : g_c8
    assign nxt_o = crc8_step(crc_q, byte_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '1;
    else if (clr_i)   crc_q <= '1;
    else if (en_i)    crc_q <= nxt_o;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/cfgrom_capture.sv
module cfgrom_capture #(
  parameter int N  = 22,
  parameter int PW = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [PW-1:0]  idx_i,
  input  logic [7:0]     byte_i,
  output logic [N*8-1:0] img_o
);
  for (genvar g = 0; g < N; g++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (wr_i && idx_i == PW'(g))     q <= byte_i;
    end
    assign img_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/cfgrom_hdr_checker.sv
module cfgrom_hdr_checker import cfgrom_pkg::*; #(
  parameter int LEN_W      = 10,
  parameter int DATA_START = 13,
  parameter int HDR_BYTES  = 22,
  parameter int SIZE_W     = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [1:0]        reason_o,
  output logic              rev_warn_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [63:0]       uid_o,
  output logic [15:0]       vendor_o,
  output logic [15:0]       model_o,
  output logic [7:0]        model_rev_o,
  output logic [7:0]        mem_rev_o
);
  localparam int ID_SUM = 0;
  localparam int ID_LO  = 1;
  localparam int ID_HI  = 8;
  localparam int DCRC   = 9;
  localparam int REV_B  = DATA_START;
  localparam int LEN_LO = 14;
  localparam int LEN_HI = 15;
  localparam int VEND   = 16;
  localparam int MODEL  = 18;
  localparam int MREV   = 20;
  localparam int NREV   = 21;

  logic [SIZE_W-1:0] pos_q, size_q;
  logic              armed_q, done_q, pass_q, warn_q;
  reason_e           reason_q;

  logic [HDR_BYTES*8-1:0] img;
  logic [7:0]  crc8_q, crc8_nxt;
  logic [31:0] crc32_q, crc32_nxt;

  logic accept, at_len_hi, short_w, last, last_short, id_ok, data_ok, warn_w;
  logic [15:0]       len_word;
  logic [SIZE_W-1:0] size_w;
  reason_e           reason_w;

  assign accept    = in_valid_i & armed_q & ~start_i;
  assign at_len_hi = pos_q == SIZE_W'(LEN_HI);
  assign len_word  = {in_data_i, img[LEN_LO*8 +: 8]};
  assign size_w    = SIZE_W'(len_word[LEN_W-1:0]) + SIZE_W'(DATA_START);
  assign short_w   = size_w < SIZE_W'(HDR_BYTES);
  assign last_short = at_len_hi & short_w;
  assign last = accept & (last_short |
                (pos_q > SIZE_W'(LEN_HI) && pos_q == size_q - SIZE_W'(1)));

  cfgrom_capture #(.N(HDR_BYTES), .PW(SIZE_W)) u_cap (
    .clk_i, .rst_ni, .wr_i(accept), .idx_i(pos_q), .byte_i(in_data_i), .img_o(img)
  );

  cfgrom_crc #(.W(8)) u_crc_id (
    .clk_i, .rst_ni, .clr_i(start_i),
    .en_i(accept && pos_q >= SIZE_W'(ID_LO) && pos_q <= SIZE_W'(ID_HI)),
    .byte_i(in_data_i), .crc_o(crc8_q), .nxt_o(crc8_nxt)
  );

  cfgrom_crc #(.W(32)) u_crc_data (
    .clk_i, .rst_ni, .clr_i(start_i),
    .en_i(accept && pos_q >= SIZE_W'(DATA_START)),
    .byte_i(in_data_i), .crc_o(crc32_q), .nxt_o(crc32_nxt)
  );

  // crc32_nxt already folds in the final byte
  assign id_ok   = crc8_q == img[ID_SUM*8 +: 8];
  assign data_ok = ~crc32_nxt == img[DCRC*8 +: 32];
  assign warn_w  = img[REV_B*8 +: 8] > 8'd1;

  always_comb begin
    if (last_short)    reason_w = RSN_SHORT;
    else if (!id_ok)   reason_w = RSN_ID_CRC;
    else if (!data_ok) reason_w = RSN_DATA_CRC;
    else               reason_w = RSN_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      size_q   <= '0;
      armed_q  <= 1'b1;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      warn_q   <= 1'b0;
      reason_q <= RSN_NONE;
    end else begin
      done_q <= last;
      if (start_i) begin
        pos_q    <= '0;
        armed_q  <= 1'b1;
        pass_q   <= 1'b0;
        warn_q   <= 1'b0;
        reason_q <= RSN_NONE;
      end else if (accept) begin
        pos_q <= pos_q + SIZE_W'(1);
        if (at_len_hi) size_q <= size_w;
        if (last) begin
          armed_q  <= 1'b0;
          reason_q <= reason_w;
          pass_q   <= reason_w == RSN_NONE;
          warn_q   <= warn_w;
        end
      end
    end
  end

  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign reason_o    = reason_q;
  assign rev_warn_o  = warn_q;
  assign size_o      = size_q;
  assign uid_o       = img[ID_LO*8 +: 64];
  assign vendor_o    = img[VEND*8 +: 16];
  assign model_o     = img[MODEL*8 +: 16];
  assign model_rev_o = img[MREV*8 +: 8];
  assign mem_rev_o   = img[NREV*8 +: 8];
endmodule

// File: rtl/cfgrom_hdr_check_sva.sv
module cfgrom_hdr_check_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        done_o,
  input logic        pass_o,
  input logic [1:0]  reason_o,
  input logic        rev_warn_o,
  input logic [63:0] uid_o
);
  logic reported_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      reported_q <= 1'b0;
    else if (start_i) reported_q <= 1'b0;
    else if (done_o)  reported_q <= 1'b1;
  end

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_pass_reason: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> reason_o == 2'd0);

  a_r7_fail_reason: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> reason_o != 2'd0);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reported_q && !start_i) |=> (!done_o && $stable(pass_o) && $stable(reason_o)
                                  && $stable(rev_warn_o) && $stable(uid_o)));

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !pass_o && reason_o == 2'd0));
endmodule

bind cfgrom_hdr_checker cfgrom_hdr_check_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
  .pass_o(pass_o), .reason_o(reason_o), .rev_warn_o(rev_warn_o), .uid_o(uid_o)
);

// File: tb/cfgrom_hdr_checker_test.sv
`timescale 1ns/1ps
module cfgrom_hdr_checker_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic in_valid_i = 1'b0;
  logic [7:0] in_data_i = 8'd0;
  logic done_o, pass_o, rev_warn_o;
  logic [1:0] reason_o;
  logic [10:0] size_o;
  logic [63:0] uid_o;
  logic [15:0] vendor_o, model_o;
  logic [7:0] model_rev_o, mem_rev_o;

  always #2.5 clk = ~clk;

  cfgrom_hdr_checker uut (
    .clk_i(clk), .rst_ni, .start_i, .in_valid_i, .in_data_i,
    .done_o, .pass_o, .reason_o, .rev_warn_o, .size_o, .uid_o,
    .vendor_o, .model_o, .model_rev_o, .mem_rev_o
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] img [0:1099];
  logic [63:0] exp_uid;
  int acc_cnt, done_cnt, done_at;
  logic l_pass, l_warn;
  logic [1:0] l_reason;

  always @(posedge clk) if (in_valid_i && !start_i) acc_cnt <= acc_cnt + 1;
  always @(negedge clk) if (done_o) begin
    done_cnt++;
    done_at  = acc_cnt - 1;
    l_pass   = pass_o;
    l_reason = reason_o;
    l_warn   = rev_warn_o;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc8(input int a, input int n);
    logic [7:0] c = 8'hFF;
    for (int i = a; i < a + n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[7] ^ img[i][b];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c;
  endfunction

  // non-reflected formulation with bit-reversed bytes
  function automatic logic [31:0] ref_crc32c(input int a, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] r;
    for (int i = a; i < a + n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[31] ^ img[i][b];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h1EDC_6F41 : 32'h0);
      end
    end
    for (int b = 0; b < 32; b++) r[b] = c[31-b];
    return ~r;
  endfunction

  function automatic void build(input int len, input logic [7:0] rev, input bit bad_id,
                                input bit bad_data, input logic [7:0] seed);
    logic [7:0] c8;
    logic [31:0] c32;
    logic [9:0] l10 = 10'(len);
    for (int i = 0; i < len + 13 || i < 22; i++) img[i] = 8'(i * 7) + seed;
    exp_uid = 64'h0123_4567_89AB_CDEF ^ {8{seed}};
    for (int k = 1; k <= 8; k++) img[k] = exp_uid[8*(k-1) +: 8];
    img[13] = rev;
    img[14] = l10[7:0];
    img[15] = {6'b110101, l10[9:8]};
    img[16] = 8'hCD; img[17] = 8'hAB;
    img[18] = 8'h34; img[19] = 8'h12;
    img[20] = 8'h5A; img[21] = 8'hA5;
    c8 = ref_crc8(1, 8);
    img[0] = bad_id ? (c8 ^ 8'h01) : c8;
    c32 = ref_crc32c(13, len);
    if (bad_data) c32 = c32 ^ 32'h0000_0100;
    for (int k = 0; k < 4; k++) img[9+k] = c32[8*k +: 8];
  endfunction

  task automatic send(input int n, input bit gaps);
    @(negedge clk);
    acc_cnt = 0; done_cnt = 0; done_at = -1;
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 4 == 2)) begin
        in_valid_i = 1'b0;
        @(negedge clk);
      end
      in_valid_i = 1'b1;
      in_data_i  = img[i];
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "reason after start", 64'(reason_o), 64'd0);
    chk("R2", "pass after start", 64'(pass_o), 64'd0);
  endtask

  task automatic run_image(input string req, input int len, input logic [7:0] rev,
                           input bit bad_id, input bit bad_data, input bit gaps,
                           input logic [1:0] exp_reason);
    pulse_start();
    build(len, rev, bad_id, bad_data, 8'(len));
    send(len + 13, gaps);
    chk("R11", "done pulses", 64'(done_cnt), 64'd1);
    chk("R11", "done position", 64'(done_at), 64'(len + 12));
    chk("R3", "size", 64'(size_o), 64'(len + 13));
    chk(req, "reason", 64'(l_reason), 64'(exp_reason));
    chk("R7", "pass", 64'(l_pass), 64'(exp_reason == 2'd0));
    chk("R8", "rev warn", 64'(l_warn), 64'(rev > 8'd1));
    chk("R7", "reason held", 64'(reason_o), 64'(exp_reason));
    chk("R9", "uid", uid_o, exp_uid);
    chk("R9", "vendor", 64'(vendor_o), 64'hABCD);
    chk("R9", "model", 64'(model_o), 64'h1234);
    chk("R9", "model rev", 64'(model_rev_o), 64'h5A);
    chk("R9", "mem rev", 64'(mem_rev_o), 64'hA5);
  endtask

  task automatic test_reset();
    chk("R1", "done", 64'(done_o), 64'd0);
    chk("R1", "pass", 64'(pass_o), 64'd0);
    chk("R1", "reason", 64'(reason_o), 64'd0);
    chk("R1", "warn", 64'(rev_warn_o), 64'd0);
  endtask

  task automatic test_crc_model();
    string s = "123456789";
    for (int i = 0; i < 9; i++) img[i] = s[i];
    chk("R6", "bench crc32c model", 64'(ref_crc32c(0, 9)), 64'hE306_9283);
  endtask

  task automatic test_short();
    pulse_start();
    build(5, 8'd1, 1'b0, 1'b0, 8'h11);
    send(18, 1'b0);
    chk("R4", "done pulses", 64'(done_cnt), 64'd1);
    chk("R4", "done position", 64'(done_at), 64'd15);
    chk("R4", "reason", 64'(l_reason), 64'd1);
    chk("R4", "pass", 64'(l_pass), 64'd0);
    chk("R3", "size", 64'(size_o), 64'd18);
  endtask

  task automatic test_ignore_after();
    logic [63:0] uid_before;
    run_image("R6", 9, 8'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    uid_before = uid_o;
    build(20, 8'd3, 1'b0, 1'b1, 8'h77);
    send(33, 1'b0);
    chk("R10", "no done", 64'(done_cnt), 64'd0);
    chk("R10", "pass held", 64'(pass_o), 64'd1);
    chk("R10", "reason held", 64'(reason_o), 64'd0);
    chk("R10", "warn held", 64'(rev_warn_o), 64'd0);
    chk("R10", "uid held", uid_o, uid_before);
  endtask

  task automatic test_abort();
    pulse_start();
    build(30, 8'd0, 1'b1, 1'b1, 8'h42);
    send(17, 1'b0);
    chk("R2", "no done on partial", 64'(done_cnt), 64'd0);
    run_image("R2", 12, 8'd1, 1'b0, 1'b0, 1'b0, 2'd0);
  endtask

  initial begin
    #(200_000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_crc_model();
    run_image("R5", 9, 8'd1, 1'b0, 1'b0, 1'b0, 2'd0);
    run_image("R8", 40, 8'd2, 1'b0, 1'b0, 1'b1, 2'd0);
    run_image("R5", 20, 8'd0, 1'b1, 1'b1, 1'b0, 2'd2);
    run_image("R6", 25, 8'd0, 1'b0, 1'b1, 1'b1, 2'd3);
    run_image("R3", 1023, 8'd1, 1'b0, 1'b0, 1'b0, 2'd0);
    test_short();
    test_ignore_after();
    test_abort();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule